// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. Two cascaded ratios set the division. A 2-bit prescaler index picks a small non-binary ratio. A 4-bit scaler index picks an even ratio from a fixed table. The serial clock period is the product of the two ratios, counted in system clocks.

While the enable is low, the serial clock rests at the selected idle polarity. Once the enable is raised, the clock starts toggling after one full half-period, so the first pulse is never shortened. Alongside the clock, the block emits two single-cycle strobes. One marks each leading edge, where the clock leaves its idle level. The other marks each trailing edge, where the clock returns to its idle level. A data shifter uses these strobes to sample and launch bits.

The ratio indices and the polarity are captured when the block leaves the idle state. This keeps every period intact even if the index fields change during a transfer.

Top module: `spi_sck_divider`

## Requirements
- R1: While reset is asserted (rst_n low), lead_pulse and trail_pulse are 0 and sck equals the cpol input.
- R2: While the block is idle (en low, or in the cycle after en is first sampled low), sck follows the cpol input and both strobes stay 0.
- R3: The prescaler index pre_sel selects ratio 2, 3, 5 or 7 for the values 0, 1, 2 or 3.
- R4: The scaler index scl_sel selects a ratio as follows. The values 0, 1, 2 and 3 give 2, 4, 6 and 8. A value k of 4 or more gives 2 to the power k.
- R5: With P the prescaler ratio and S the scaler ratio, the high phase and the low phase of sck each last exactly P*S/2 system clocks. A full period is therefore P*S system clocks, including when P is odd.
- R6: Let edge A be the rising system clock edge at which en is first sampled high. The first sck transition occurs at edge A+P*S/2, and later transitions follow every P*S/2 edges.
- R7: lead_pulse is high for exactly the one cycle after each sck transition away from the captured idle level. trail_pulse is high for exactly the one cycle after each transition back to it. The two strobes are never high together.
- R8: Changes to pre_sel, scl_sel or cpol while the block is running have no effect on sck or the strobes. The values captured at edge A stay in use until en goes low.
- R9: When en is sampled low, at the next edge sck returns to the cpol level, both strobes drop to 0, and a later enable restarts with a full first half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request; low holds the clock idle |
| cpol | input | 1 | Idle level of sck |
| pre_sel | input | 2 | Prescaler ratio index |
| scl_sel | input | 4 | Scaler ratio index |
| sck | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe after each leading sck edge |
| trail_pulse | output | 1 | One-cycle strobe after each trailing sck edge |

## Verification
The bench numbers every system clock edge from edge A, the edge at which en is first seen high. For an edge index n and a half-period h, it computes the expected sck level as the idle level inverted (n/h) times. A strobe is expected exactly when n is a nonzero multiple of h. Every sample is taken on the falling clock edge, after the register update of edge A+n. This places each transition exactly h edges after the previous one, with no slack. For disable, the bench expects the idle level right after the first edge that sees en low. Index and polarity changes are injected mid-run, and the expected waveform still uses the values captured at edge A.

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int CNT_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cpol,
  input  logic [1:0] pre_sel,
  input  logic [3:0] scl_sel,
  output logic       sck,
  output logic       lead_pulse,
  output logic       trail_pulse
);

  function automatic logic [CNT_W-1:0] half_ratio(input logic [1:0] p, input logic [3:0] s);
    int unsigned pr, sh;
    case (p)
      2'd0: pr = 2;
      2'd1: pr = 3;
      2'd2: pr = 5;
      default: pr = 7;
    endcase
    sh = (s < 4'd4) ? (32'(s) + 1) : (32'd1 << (32'(s) - 1));
    return CNT_W'(pr * sh);
  endfunction

  logic             active_q, cpol_q, sck_q, lead_q, trail_q;
  logic [CNT_W-1:0] cnt_q, half_q;
  logic             wrap;

  assign wrap = (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cpol_q   <= 1'b0;
      sck_q    <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      cnt_q    <= '0;
      half_q   <= '0;
    end else if (!en) begin
      active_q <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      half_q   <= half_ratio(pre_sel, scl_sel);
      cpol_q   <= cpol;
      sck_q    <= cpol;
      cnt_q    <= '0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      sck_q   <= ~sck_q;
      lead_q  <= (sck_q == cpol_q);
      trail_q <= (sck_q != cpol_q);
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end
  end

  assign sck         = active_q ? sck_q : cpol;
  assign lead_pulse  = lead_q;
  assign trail_pulse = trail_q;

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && trail_q));

  // R7
  lead_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sck_q != cpol_q));

  // R7
  trail_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sck_q == cpol_q));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!lead_q && !trail_q));

  // R8
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> ($stable(half_q) && $stable(cpol_q)));

  // R5
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < half_q));

endmodule

// File: tb/spi_sck_divider_tb.sv
module spi_sck_divider_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cpol = 1'b0;
  logic [1:0] pre_sel = '0;
  logic [3:0] scl_sel = '0;
  logic sck, lead_pulse, trail_pulse;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_sck_divider dut_i (.clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
    .pre_sel(pre_sel), .scl_sel(scl_sel), .sck(sck),
    .lead_pulse(lead_pulse), .trail_pulse(trail_pulse));

  function automatic int exp_half(input int p, input int s);
    int pr, sr;
    pr = (p == 0) ? 2 : (p == 1) ? 3 : (p == 2) ? 5 : 7;
    sr = (s < 4) ? 2 * (s + 1) : (1 << s);
    return pr * sr / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // en set at a negedge; next posedge is edge A. Checks n = 0..last.
  task automatic run(input int p, input int s, input bit pol, input int nmax, input bit perturb);
    int h;
    h = exp_half(p, s);
    pre_sel = 2'(p); scl_sel = 4'(s); cpol = pol; en = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= nmax; n++) begin
      if (n > 0) @(posedge clk);
      @(negedge clk);
      chk("R6/R5 sck", int'(sck), int'(pol ^ ((n / h) % 2 == 1)));
      chk("R7 lead", int'(lead_pulse), int'(n > 0 && n % h == 0 && (n / h) % 2 == 1));
      chk("R7 trail", int'(trail_pulse), int'(n > 0 && n % h == 0 && (n / h) % 2 == 0));
      if (perturb && n == h / 2 + 1) begin
        pre_sel = 2'($urandom); scl_sel = 4'($urandom); cpol = ~pol;  // R8
      end
    end
    en = 1'b0;
    cpol = $urandom;
    @(posedge clk); @(negedge clk);
    chk("R9 sck idle", int'(sck), int'(cpol));
    chk("R9 lead", int'(lead_pulse), 0);
    chk("R9 trail", int'(trail_pulse), 0);
    cpol = ~cpol;
    @(posedge clk); @(negedge clk);
    chk("R2 sck follows cpol", int'(sck), int'(cpol));
    chk("R2 strobes", int'(lead_pulse | trail_pulse), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cpol = 1'b1;
    #20;
    chk("R1 sck", int'(sck), 1);
    chk("R1 strobes", int'(lead_pulse | trail_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle sck", int'(sck), 1);
    // R3 R4 directed: every prescaler and low scaler indices
    for (int p = 0; p < 4; p++) run(p, 0, p[0], 4 * exp_half(p, 0) + 1, 0);
    for (int s = 0; s < 8; s++) run(1, s, s[0], 2 * exp_half(1, s) + 1, 0);
    run(0, 15, 1'b0, 2 * exp_half(0, 15) + 1, 0);   // R4 largest scaler
    run(3, 12, 1'b1, exp_half(3, 12) + 2, 0);       // R5 odd prescaler, large
    // R8 random with mid-run perturbation
    for (int t = 0; t < 20; t++) begin
      int p, s;
      p = $urandom_range(3); s = $urandom_range(6);
      run(p, s, 1'($urandom), 3 * exp_half(p, s) + 1, 1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule